// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block lets an external host read and write a small byte-wide register file inside the chip. The host uses three wires: a serial clock, an active-low select and one shared data line. The block does not run from the host clock. It oversamples all three wires in the chip clock domain and finds the serial clock edges there. The data line comes into the block as a separate input and output with an output enable, so the pad ring can build the bidirectional pin from them.

Each frame opens with a 16-bit instruction. The instruction gives the transfer direction, a byte-count code and a 13-bit start address. Data bytes follow it. On a read, the block takes over the data line straight after the instruction and shifts out register contents. The address moves by one after every byte. With the stream code, a frame runs on for as long as select stays low. In a fixed-length frame, the host may raise select between bytes to pause. The bit order of data bytes comes from one bit of the configuration register. All register contents are also brought out in parallel for use by the rest of the chip.

Top module: `tri_wire_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, `sdio_oe` is low and data bytes use MSB-first order.
- R2: A frame starts when `cs_n` falls. The first bit is taken on the next rising `sclk` edge. The 16-bit instruction always arrives MSB-first, with bit 15 = direction (1 read, 0 write), bits 14:13 = length code and bits 12:0 = start address.
- R3: Length code 00 moves 1 byte, 01 moves 2 bytes and 10 moves 3 bytes. Clock edges after the last byte change no register until `cs_n` goes high and falls again.
- R4: Length code 11 streams bytes until `cs_n` rises, and the rise ends the frame.
- R5: On a write, data bits are sampled on rising `sclk` edges. Each completed byte is written to the current address.
- R6: On a read, `sdio_oe` goes high after the 16th instruction bit. Each data bit is launched on a falling `sclk` edge and is valid at the following rising edge.
- R7: After each byte the address steps by one: it decrements in MSB-first order and increments in LSB-first order.
- R8: Bit 0 of register 0x000 set to 1 makes data bytes LSB-first (bit 0 first). Set to 0, data bytes are MSB-first. The instruction stays MSB-first in both cases.
- R9: In a fixed-length frame, a high `cs_n` at a byte boundary keeps the frame position, and the next low continues with the next byte. A high `cs_n` during the instruction or in the middle of a byte aborts the frame without writing.
- R10: Addresses at or above the register count (8 by default) are unimplemented. Writes to them change nothing and reads of them return 0x00.
- R11: `sdio_oe` is low in write frames, while idle and after a read frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that oversamples the serial wires |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select from the host |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Read data to drive onto the line |
| sdio_oe | output | 1 | High while the block drives the data line |
| reg_image | output | NREG*8 | All registers, register i at bits 8i+7:8i |

## Verification
Writes and reads are tried with one, two and three bytes and with a stream of four. Together these separate the handling of each length code and show that the address moves down for each byte in MSB-first order. A further frame sends extra clocks after a one-byte write, which shows that the frame really stops at its length. A pause at a byte boundary is set against a select rise in the middle of a byte: the first must complete both writes and the second must write nothing. Asymmetric data bytes are sent after the order bit is set, which shows both the bit reversal and the change to an incrementing address. Unimplemented addresses are written and read to show that no register aliases them.

// File: rtl/tri_wire_cfg_pkg.sv
// Package tri_wire_cfg_pkg
// Shared types and the fixed instruction layout of the three-wire port.
// Assumes the instruction is 16 bits with 13 address bits; these widths are
// part of the wire format and therefore not parameters of the instances.
package tri_wire_cfg_pkg;
    localparam int INSTR_W  = 16;
    localparam int ADDR_W   = 13;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(INSTR_W);
    localparam logic [1:0] LEN_STREAM = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INSTR,
        ST_DATA,
        ST_DONE
    } frame_st_e;
endpackage

// File: rtl/tri_wire_sync.sv
// Module tri_wire_sync
// Brings N asynchronous wires into the clk domain through STAGES flops each.
// Assumes STAGES >= 2 and that each wire holds steady for several clk cycles.
module tri_wire_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level
);
    for (genvar g = 0; g < N; g++) begin : g_wire
        logic [STAGES-1:0] chain;

        // Shift the raw wire through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end

        assign level[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/tri_wire_regs.sv
// Module tri_wire_regs
// Byte-wide register file at addresses 0..NREG-1. Register CFG_ADDR holds the
// bit-order flag at bit ORDER_BIT. Assumes one write strobe per byte; other
// addresses are not decoded, so they read as zero and take no writes.
module tri_wire_regs
    import tri_wire_cfg_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int CFG_ADDR  = 0,
    parameter int ORDER_BIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic                 lsb_first,
    output logic [NREG*BYTE_W-1:0] flat
);
    localparam int                IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

    logic [BYTE_W-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold one register; load it when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                mem[g] <= wr_data;
        end
        assign flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    // Read mux with zero for unimplemented addresses
    always_comb begin
        if (rd_addr < NREG_A) rd_data = mem[rd_addr[IDX_W-1:0]];
        else                  rd_data = '0;
    end

    assign lsb_first = mem[CFG_ADDR][ORDER_BIT];

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= NREG_A) |=> $stable(flat)); // R10
endmodule

// File: rtl/tri_wire_frame.sv
// Module tri_wire_frame
// Frame engine: assembles the instruction, counts data bits and bytes, steps
// the address, issues register writes and launches read bits. Assumes single
// clk-cycle edge strobes for sclk and select that never coincide.
module tri_wire_frame
    import tri_wire_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              din,
    input  logic              lsb_first,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_en
);
    frame_st_e          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [INSTR_W-2:0] instr_sh;
    logic               is_read;
    logic [1:0]         len;
    logic [1:0]         byte_idx;
    logic [ADDR_W-1:0]  addr;
    logic [BYTE_W-1:0]  rx;
    logic [INSTR_W-1:0] instr_word;
    logic [BYTE_W-1:0]  rx_next;
    logic [ADDR_W-1:0]  addr_step;
    logic               in_read;

    // Next values built from the bit arriving now
    always_comb begin
        instr_word = {instr_sh, din};
        rx_next    = lsb_first ? {din, rx[BYTE_W-1:1]} : {rx[BYTE_W-2:0], din};
        addr_step  = lsb_first ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
        in_read    = (state == ST_DATA) && is_read;
    end

    // Frame sequencing on select edges and rising serial clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            instr_sh <= '0;
            is_read  <= 1'b0;
            len      <= '0;
            byte_idx <= '0;
            addr     <= '0;
            rx       <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (cs_rise) begin
                if (!(state == ST_DATA && len != LEN_STREAM && bit_cnt == '0))
                    state <= ST_IDLE;
            end else if (cs_fall) begin
                if (state != ST_DATA) begin
                    state    <= ST_INSTR;
                    bit_cnt  <= '0;
                    byte_idx <= '0;
                end
            end else if (sclk_rise && cs_low) begin
                case (state)
                    ST_INSTR: begin
                        instr_sh <= instr_word[INSTR_W-2:0];
                        if (bit_cnt == CNT_W'(INSTR_W-1)) begin
                            is_read <= instr_word[INSTR_W-1];
                            len     <= instr_word[INSTR_W-2:INSTR_W-3];
                            addr    <= instr_word[ADDR_W-1:0];
                            bit_cnt <= '0;
                            state   <= ST_DATA;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_DATA: begin
                        rx <= rx_next;
                        if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                            bit_cnt  <= '0;
                            wr_en    <= !is_read;
                            wr_addr  <= addr;
                            wr_data  <= rx_next;
                            addr     <= addr_step;
                            byte_idx <= byte_idx + 2'd1;
                            if (len != LEN_STREAM && byte_idx == len)
                                state <= ST_DONE;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Launch read bits on falling serial clock edges
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= 1'b0;
        else if (!in_read)
            dout <= 1'b0;
        else if (sclk_fall && cs_low)
            dout <= lsb_first ? rd_data[bit_cnt[2:0]] : rd_data[3'd7 - bit_cnt[2:0]];
    end

    assign rd_addr = addr;
    assign dout_en = in_read && cs_low;

    AST_START_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && (state == ST_IDLE || state == ST_DONE)) |=> (state == ST_INSTR && bit_cnt == '0)); // R2
    AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSTR && sclk_rise && cs_low && !cs_rise && !cs_fall &&
         bit_cnt == CNT_W'(INSTR_W-1) && instr_sh[INSTR_W-2]) |=> (dout_en || !cs_low)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && sclk_rise && cs_low && !cs_rise && !cs_fall && bit_cnt == CNT_W'(BYTE_W-1))
        |=> (addr == ($past(lsb_first) ? $past(addr) + ADDR_W'(1) : $past(addr) - ADDR_W'(1)))); // R7
    AST_STALL_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && state == ST_DATA && len != LEN_STREAM && bit_cnt == '0) |=> (state == ST_DATA)); // R9
    AST_MIDWORD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && (state == ST_INSTR || (state == ST_DATA && bit_cnt != '0))) |=> (state == ST_IDLE)); // R9
    AST_STREAM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && state == ST_DATA && len == LEN_STREAM) |=> (state == ST_IDLE && !dout_en)); // R4
endmodule

// File: rtl/tri_wire_cfg_port.sv
// Module tri_wire_cfg_port
// Top of the three-wire configuration port: synchronizes the host wires,
// detects serial clock and select edges, and connects the frame engine to
// the register file. Assumes the host clock is much slower than clk (at least
// four clk cycles per serial clock phase).
module tri_wire_cfg_port
    import tri_wire_cfg_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   sdio_in,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    output logic [NREG*BYTE_W-1:0] reg_image
);
    localparam int           N_WIRES   = 3;
    localparam logic [2:0]   WIRE_RST  = 3'b100;

    logic [N_WIRES-1:0] wires_s;
    logic               csn_s, sclk_s, din_s;
    logic               csn_q, sclk_q;
    logic               sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic               wr_en, lsb_first;
    logic [ADDR_W-1:0]  wr_addr, rd_addr;
    logic [BYTE_W-1:0]  wr_data, rd_data;

    tri_wire_sync #(
        .N       (N_WIRES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (WIRE_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({cs_n, sclk, sdio_in}),
        .level (wires_s)
    );

    assign {csn_s, sclk_s, din_s} = wires_s;

    // Keep the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            csn_q  <= csn_s;
            sclk_q <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_fall   = ~csn_s & csn_q;
    assign cs_rise   = csn_s & ~csn_q;

    tri_wire_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_low    (~csn_s),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .din       (din_s),
        .lsb_first (lsb_first),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (sdio_out),
        .dout_en   (sdio_oe)
    );

    tri_wire_regs #(
        .NREG      (NREG),
        .CFG_ADDR  (0),
        .ORDER_BIT (0)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .lsb_first (lsb_first),
        .flat      (reg_image)
    );
endmodule

// File: tb/tri_wire_cfg_port_tb.sv
// Directed bench for tri_wire_cfg_port: one task per scenario, each checking
// its own results against a register model kept from the requirements.
module tri_wire_cfg_port_tb;
    localparam int NREG = 8;
    localparam int HALF = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sclk = 1'b0;
    logic              cs_n = 1'b1;
    logic              sdio_in = 1'b0;
    logic              sdio_out;
    logic              sdio_oe;
    logic [NREG*8-1:0] reg_image;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    bit   lsb_mode = 1'b0;
    bit   oe_seen = 1'b0;
    logic [7:0] model [NREG];

    tri_wire_cfg_port #(.NREG(NREG), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .reg_image (reg_image)
    );

    always #5 clk = ~clk;

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    // One serial bit: drive, wait, sample read data, rising edge, falling edge
    task automatic shift_bit(input logic b, output logic got);
        sdio_in = b;
        wait_half();
        got = sdio_out;
        if (sdio_oe) oe_seen = 1'b1;
        sclk = 1'b1;
        wait_half();
        sclk = 1'b0;
    endtask

    task automatic open_frame();
        oe_seen = 1'b0;
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic close_frame();
        wait_half();
        cs_n = 1'b1;
        wait_half();
        wait_half();
    endtask

    task automatic send_instr(input bit rd, input logic [1:0] len, input logic [12:0] a);
        logic [15:0] w;
        logic        g;
        w = {rd, len, a};
        for (int i = 15; i >= 0; i--) shift_bit(w[i], g);
    endtask

    task automatic xfer_byte(input logic [7:0] d, output logic [7:0] q, output bit oe_all);
        logic g;
        oe_all = 1'b1;
        q = '0;
        for (int i = 0; i < 8; i++) begin
            int k;
            k = lsb_mode ? i : 7 - i;
            sdio_in = d[k];
            wait_half();
            q[k] = sdio_out;
            if (!sdio_oe) oe_all = 1'b0;
            else oe_seen = 1'b1;
            sclk = 1'b1;
            wait_half();
            sclk = 1'b0;
        end
        g = 1'b0;
    endtask

    task automatic write_frame(input logic [1:0] len, input logic [12:0] a, input int n, input logic [7:0] d0,
                               input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3);
        logic [7:0] q;
        bit         oe_all;
        logic [7:0] d [4];
        d = '{d0, d1, d2, d3};
        open_frame();
        send_instr(1'b0, len, a);
        for (int i = 0; i < n; i++) xfer_byte(d[i], q, oe_all);
        close_frame();
    endtask

    task automatic test_reset();
        check("R1", "register image after reset", reg_image, '0);
        check("R1", "output enable after reset", sdio_oe, 1'b0);
    endtask

    task automatic test_single_write();
        write_frame(2'b00, 13'd3, 1, 8'hA5, 8'h00, 8'h00, 8'h00);
        model[3] = 8'hA5;
        check("R5", "single byte write to 3", reg_image, model_flat());
        check("R11", "oe seen during write frame", oe_seen, 1'b0);
    endtask

    task automatic test_single_read();
        logic [7:0] q;
        bit         oe_all;
        open_frame();
        send_instr(1'b1, 2'b00, 13'd3);
        xfer_byte(8'h00, q, oe_all);
        check("R6", "read data from 3", q, 8'hA5);
        check("R6", "oe held through read byte", oe_all, 1'b1);
        close_frame();
        check("R11", "oe after read frame", sdio_oe, 1'b0);
    endtask

    task automatic test_multi_msb();
        logic [7:0] q0, q1;
        bit         oe_all;
        write_frame(2'b10, 13'd6, 3, 8'h16, 8'h25, 8'h34, 8'h00);
        model[6] = 8'h16; model[5] = 8'h25; model[4] = 8'h34;
        check("R3", "three byte write downward from 6", reg_image, model_flat());
        open_frame();
        send_instr(1'b1, 2'b01, 13'd6);
        xfer_byte(8'h00, q0, oe_all);
        xfer_byte(8'h00, q1, oe_all);
        close_frame();
        check("R7", "two byte read first byte", q0, 8'h16);
        check("R7", "two byte read second byte", q1, 8'h25);
    endtask

    task automatic test_length_limit();
        logic [7:0] q;
        bit         oe_all;
        open_frame();
        send_instr(1'b0, 2'b00, 13'd2);
        xfer_byte(8'h11, q, oe_all);
        xfer_byte(8'hFF, q, oe_all);
        close_frame();
        model[2] = 8'h11;
        check("R3", "clocks past single byte ignored", reg_image, model_flat());
    endtask

    task automatic test_stream();
        logic [7:0] q [4];
        bit         oe_all;
        write_frame(2'b11, 13'd7, 4, 8'hC7, 8'hC6, 8'hC5, 8'hC4);
        model[7] = 8'hC7; model[6] = 8'hC6; model[5] = 8'hC5; model[4] = 8'hC4;
        check("R4", "four byte stream write", reg_image, model_flat());
        open_frame();
        send_instr(1'b1, 2'b11, 13'd7);
        for (int i = 0; i < 4; i++) xfer_byte(8'h00, q[i], oe_all);
        close_frame();
        check("R4", "stream read bytes", {q[0], q[1], q[2], q[3]}, 32'hC7C6C5C4);
        check("R4", "oe after stream end", sdio_oe, 1'b0);
    endtask

    task automatic test_stall();
        logic [7:0] q;
        bit         oe_all;
        open_frame();
        send_instr(1'b0, 2'b01, 13'd2);
        xfer_byte(8'h5E, q, oe_all);
        wait_half();
        cs_n = 1'b1;
        repeat (6) wait_half();
        cs_n = 1'b0;
        wait_half();
        xfer_byte(8'h1D, q, oe_all);
        close_frame();
        model[2] = 8'h5E; model[1] = 8'h1D;
        check("R9", "pause between bytes keeps frame", reg_image, model_flat());
    endtask

    task automatic test_abort();
        logic g;
        open_frame();
        send_instr(1'b0, 2'b00, 13'd1);
        for (int i = 0; i < 4; i++) shift_bit(1'b0, g);
        close_frame();
        check("R9", "select rise mid-byte aborts", reg_image, model_flat());
        write_frame(2'b00, 13'd1, 1, 8'h77, 8'h00, 8'h00, 8'h00);
        model[1] = 8'h77;
        check("R9", "next frame after abort", reg_image, model_flat());
    endtask

    task automatic test_unmapped();
        logic [7:0] q;
        bit         oe_all;
        write_frame(2'b00, 13'h100, 1, 8'h5A, 8'h00, 8'h00, 8'h00);
        check("R10", "write to 0x100 ignored", reg_image, model_flat());
        write_frame(2'b00, 13'd8, 1, 8'h5A, 8'h00, 8'h00, 8'h00);
        check("R10", "write to 8 ignored", reg_image, model_flat());
        open_frame();
        send_instr(1'b1, 2'b00, 13'h100);
        xfer_byte(8'h00, q, oe_all);
        close_frame();
        check("R10", "read of 0x100", q, 8'h00);
    endtask

    task automatic test_lsb_first();
        logic [7:0] q0, q1;
        bit         oe_all;
        write_frame(2'b00, 13'd0, 1, 8'h01, 8'h00, 8'h00, 8'h00);
        model[0] = 8'h01;
        lsb_mode = 1'b1;
        check("R8", "order bit set", reg_image, model_flat());
        write_frame(2'b01, 13'd2, 2, 8'h3C, 8'h81, 8'h00, 8'h00);
        model[2] = 8'h3C; model[3] = 8'h81;
        check("R8", "LSB-first write upward from 2", reg_image, model_flat());
        open_frame();
        send_instr(1'b1, 2'b01, 13'd2);
        xfer_byte(8'h00, q0, oe_all);
        xfer_byte(8'h00, q1, oe_all);
        close_frame();
        check("R7", "LSB-first read increments", {q0, q1}, 16'h3C81);
        write_frame(2'b00, 13'd0, 1, 8'h00, 8'h00, 8'h00, 8'h00);
        model[0] = 8'h00;
        lsb_mode = 1'b0;
        check("R8", "order bit cleared", reg_image, model_flat());
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        test_reset();
        test_single_write();
        test_single_read();
        test_multi_msb();
        test_length_limit();
        test_stream();
        test_stall();
        test_abort();
        test_unmapped();
        test_lsb_first();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule